// File: doc/BRIEF.md
# Serialized Interrupt Host Controller

This block is the host end of a single-wire, open-drain serialized interrupt bus. Each transfer cycle begins with a start frame. A source phase follows, in which 17 interrupt sources each report a level in a slot of three states. A stop frame closes the cycle. The host samples the line at the opening state of every slot and holds the results in a shadow register. At the end of the stop frame it copies all 17 levels into the output status vector in one clock.

The length of the low part of the stop frame tells every slave which mode the next cycle uses. Two low states select quiet mode and three select continuous mode. In continuous mode the host starts cycles on its own, after a programmable number of idle states. In quiet mode the host leaves the line released until a slave pulls it low for one state. The host then drives the rest of that start frame. The host drives the line only by enabling a low driver. At all other times a pull-up holds the line high.

Top module: `sirq_host`

## Requirements
- R1: While reset is asserted and just after it, the line driver is off, every status bit reads 0 and quiet_mode_o reads 0, which means continuous mode.
- R2: In continuous mode the line stays released for period_i+1 states after the stop frame ends, and then the host starts a cycle.
- R3: A host-started cycle opens with a 6-state start frame: the driver is on in states 0 to 3 and off in states 4 and 5.
- R4: In quiet mode the host never starts a cycle without a slave request, however long the line stays idle.
- R5: In quiet mode, when the line is sampled low in an idle state, that state counts as start state 0. The host then drives the line low in states 1 to 3 and releases it in states 4 and 5.
- R6: The 17 source slots follow the start frame, 3 states each. Status bit k belongs to slot k: bit 0 is IRQ0, bit 1 is IRQ1, bit 2 is SMI, bit n is IRQn for n from 3 to 15, and bit 16 is IOCHCK. A bit reads 1 when the line was low in the first state of its slot. Levels in the second and third states of a slot are ignored.
- R7: The stop frame holds the line released for max(1, stop_idle_i) states. It then drives the line low for 2 states when quiet_req_i is 1, or for 3 states when quiet_req_i is 0.
- R8: irq_status_o changes only at the clock edge that ends the stop frame, and all 17 bits change together.
- R9: quiet_mode_o changes only at the end of the stop frame, and it takes the mode that the stop frame signalled.
- R10: The host driver is off through all 17 source slots and through the released part of the stop frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; one state per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sirq_i | input | 1 | Sampled level of the serial interrupt line |
| sirq_oe_o | output | 1 | Enables the host's low driver on the line |
| quiet_req_i | input | 1 | 1 requests quiet mode for the next cycle, 0 requests continuous mode |
| period_i | input | PERIOD_W | Idle states minus one between cycles in continuous mode |
| stop_idle_i | input | STOP_IDLE_W | Released states at the start of the stop frame; 0 is treated as 1 |
| irq_status_o | output | 17 | Latched source levels, 1 = asserted |
| quiet_mode_o | output | 1 | Current mode, 1 = quiet |

## Verification
The hardest case to reach from the ports is the quiet-mode start, because the slave pulls the line low for one state while the host is still idle. A cycle that began this way must then line up its slot sampling exactly like a host-started one. The bench runs a behavioural slave. It switches the controller into quiet mode with a 2-state stop frame, waits a random idle gap, and then pulls the line low for exactly one state, sometimes in the very first idle state. After that it drives slot levels against the cycle timing given in the requirements. In the second and third states of unasserted slots it adds random low noise, which shows that only the first state of each slot is sampled.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int NUM_SRC   = 17;
  localparam int START_LEN = 6;
  localparam int START_LOW = 4;
  localparam int SLOT_LEN  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SRC,
    ST_STOP_IDLE,
    ST_STOP_LOW
  } sirq_st_e;
endpackage

// File: rtl/sirq_seq.sv
module sirq_seq
  import sirq_pkg::*;
#(
  parameter int PERIOD_W    = 8,
  parameter int STOP_IDLE_W = 3,
  localparam int CNT_W      = (STOP_IDLE_W > 3) ? STOP_IDLE_W : 3,
  localparam int FRM_W      = $clog2(NUM_SRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sirq_i,
  input  logic                   quiet_req_i,
  input  logic [PERIOD_W-1:0]    period_i,
  input  logic [STOP_IDLE_W-1:0] stop_idle_i,
  output logic                   drive_o,
  output logic                   sample_o,
  output logic [FRM_W-1:0]       slot_o,
  output logic                   stop_done_o,
  output logic                   quiet_mode_o,
  output sirq_st_e               st_o
);
  sirq_st_e            st_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [FRM_W-1:0]    frm_q;
  logic [PERIOD_W-1:0] idle_q;
  logic                quiet_q, stop_quiet_q;
  logic [CNT_W-1:0]    idle_last, low_last;

  assign idle_last = (stop_idle_i == '0) ? '0 : CNT_W'(stop_idle_i) - CNT_W'(1);
  assign low_last  = stop_quiet_q ? CNT_W'(1) : CNT_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      cnt_q        <= '0;
      frm_q        <= '0;
      idle_q       <= '0;
      quiet_q      <= 1'b0;
      stop_quiet_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (quiet_q) begin
            // slave pulled state 0 low; continue at state 1
            if (!sirq_i) begin
              st_q  <= ST_START;
              cnt_q <= CNT_W'(1);
            end
          end else if (idle_q >= period_i) begin
            st_q   <= ST_START;
            cnt_q  <= '0;
            idle_q <= '0;
          end else begin
            idle_q <= idle_q + PERIOD_W'(1);
          end
        end
        ST_START: begin
          if (cnt_q == CNT_W'(START_LEN - 1)) begin
            st_q  <= ST_SRC;
            cnt_q <= '0;
            frm_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_SRC: begin
          if (cnt_q == CNT_W'(SLOT_LEN - 1)) begin
            cnt_q <= '0;
            if (frm_q == FRM_W'(NUM_SRC - 1)) st_q <= ST_STOP_IDLE;
            else frm_q <= frm_q + FRM_W'(1);
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_STOP_IDLE: begin
          if (cnt_q >= idle_last) begin
            st_q         <= ST_STOP_LOW;
            cnt_q        <= '0;
            stop_quiet_q <= quiet_req_i;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_STOP_LOW: begin
          if (cnt_q == low_last) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            idle_q  <= '0;
            quiet_q <= stop_quiet_q;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign drive_o      = ((st_q == ST_START) && (cnt_q <= CNT_W'(START_LOW - 1))) ||
                        (st_q == ST_STOP_LOW);
  assign sample_o     = (st_q == ST_SRC) && (cnt_q == '0);
  assign slot_o       = frm_q;
  assign stop_done_o  = (st_q == ST_STOP_LOW) && (cnt_q == low_last);
  assign quiet_mode_o = quiet_q;
  assign st_o         = st_q;
endmodule

// File: rtl/sirq_capture.sv
module sirq_capture
  import sirq_pkg::*;
#(
  localparam int FRM_W = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sirq_i,
  input  logic               sample_i,
  input  logic [FRM_W-1:0]   slot_i,
  input  logic               commit_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] shadow_q, status_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) shadow_q[k] <= 1'b0;
      else if (sample_i && (slot_i == FRM_W'(k))) shadow_q[k] <= ~sirq_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else if (commit_i) status_q <= shadow_q;
  end

  assign status_o = status_q;
endmodule

// File: rtl/sirq_host.sv
module sirq_host
  import sirq_pkg::*;
#(
  parameter int PERIOD_W    = 8,
  parameter int STOP_IDLE_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sirq_i,
  output logic                   sirq_oe_o,
  input  logic                   quiet_req_i,
  input  logic [PERIOD_W-1:0]    period_i,
  input  logic [STOP_IDLE_W-1:0] stop_idle_i,
  output logic [NUM_SRC-1:0]     irq_status_o,
  output logic                   quiet_mode_o
);
  localparam int FRM_W = $clog2(NUM_SRC);

  logic             sample;
  logic [FRM_W-1:0] slot;
  logic             stop_done;
  sirq_st_e         st;

  sirq_seq #(.PERIOD_W(PERIOD_W), .STOP_IDLE_W(STOP_IDLE_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sirq_i       (sirq_i),
    .quiet_req_i  (quiet_req_i),
    .period_i     (period_i),
    .stop_idle_i  (stop_idle_i),
    .drive_o      (sirq_oe_o),
    .sample_o     (sample),
    .slot_o       (slot),
    .stop_done_o  (stop_done),
    .quiet_mode_o (quiet_mode_o),
    .st_o         (st)
  );

  sirq_capture u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sirq_i   (sirq_i),
    .sample_i (sample),
    .slot_i   (slot),
    .commit_i (stop_done),
    .status_o (irq_status_o)
  );
endmodule

// File: rtl/sirq_host_chk.sv
module sirq_host_chk
  import sirq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sirq_i,
  input logic               sirq_oe_o,
  input logic [NUM_SRC-1:0] irq_status_o,
  input logic               quiet_mode_o,
  input logic               stop_done,
  input sirq_st_e           st
);
  logic [2:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_run_q <= '0;
    else if (!sirq_oe_o) low_run_q <= '0;
    else if (low_run_q != 3'd7) low_run_q <= low_run_q + 3'd1;
  end

  // R3
  low_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_run_q == 3'd4) |-> !sirq_oe_o);

  // R4
  quiet_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && quiet_mode_o) |-> !sirq_oe_o);

  // R5
  slave_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && quiet_mode_o && !sirq_i) |=> sirq_oe_o);

  // R8
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_done |=> $stable(irq_status_o));

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_done |=> $stable(quiet_mode_o));

  // R10
  src_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_SRC || st == ST_STOP_IDLE) |-> !sirq_oe_o);
endmodule

bind sirq_host sirq_host_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sirq_i       (sirq_i),
  .sirq_oe_o    (sirq_oe_o),
  .irq_status_o (irq_status_o),
  .quiet_mode_o (quiet_mode_o),
  .stop_done    (stop_done),
  .st           (st)
);

// File: tb/tb_sirq_host.sv
module tb_sirq_host;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slave_low = 1'b0;
  logic        sirq, oe, quiet_req, qmode;
  logic [7:0]  period;
  logic [2:0]  stop_idle;
  logic [16:0] status;

  int checks = 0, fails = 0;
  bit         m_quiet = 1'b0;
  logic [16:0] m_status = '0;

  always #5 clk = ~clk;
  assign sirq = ~(oe | slave_low);

  sirq_host dut (
    .clk_i(clk), .rst_ni(rst_n), .sirq_i(sirq), .sirq_oe_o(oe),
    .quiet_req_i(quiet_req), .period_i(period), .stop_idle_i(stop_idle),
    .irq_status_o(status), .quiet_mode_o(qmode)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_drive(int s, bit slv, int idl);
    if (s <= 3) return !(slv && s == 0);
    return s >= 57 + idl;
  endfunction

  // Enters at the negedge of the first idle state after the previous stop.
  task automatic run_cycle(input logic [16:0] mask, input bit noise,
                           input int gap, input bit chk_period);
    bit slv = m_quiet;
    int s0, n, idl, tot;
    idl = (stop_idle == 0) ? 1 : int'(stop_idle);
    tot = 57 + idl + (quiet_req ? 2 : 3);
    if (slv) begin
      for (int g = 0; g < gap; g++) begin
        chk(oe == 1'b0, "R4", "driver during quiet idle", oe, 0);
        @(negedge clk);
      end
      slave_low = 1'b1;
      @(negedge clk);
      slave_low = 1'b0;
      s0 = 1;
    end else begin
      n = 0;
      do begin @(negedge clk); n++; end while (!oe && n < 600);
      if (chk_period) chk(n == int'(period) + 1, "R2", "idle states", n, int'(period) + 1);
      s0 = 0;
    end
    for (int s = s0; s < tot; s++) begin
      string req;
      if (s > s0) @(negedge clk);
      req = (s < 6) ? (slv ? "R5" : "R3") : (s < 57 + idl) ? "R10" : "R7";
      chk(oe == exp_drive(s, slv, idl), req, $sformatf("driver state %0d", s),
          oe, exp_drive(s, slv, idl));
      slave_low = 1'b0;
      if (s >= 6 && s < 57) begin
        int f = (s - 6) / 3;
        if ((s - 6) % 3 == 0) slave_low = mask[f];
        else if (noise && !mask[f]) slave_low = 1'($urandom % 2);
      end
      if (s == 30 || s == tot - 1) begin
        chk(status == m_status, "R8", "status held mid-cycle", status, m_status);
        chk(qmode == m_quiet, "R9", "mode held mid-cycle", qmode, m_quiet);
      end
    end
    @(negedge clk);
    slave_low = 1'b0;
    m_status = mask;
    m_quiet  = quiet_req;
    chk(status == mask, "R6", "status after stop", status, mask);
    chk(qmode == m_quiet, "R9", "mode after stop", qmode, m_quiet);
    chk(oe == 1'b0, "R7", "released after stop", oe, 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    quiet_req = 1'b0; period = 8'd5; stop_idle = 3'd1;
    repeat (3) @(negedge clk);
    chk(oe == 1'b0, "R1", "driver in reset", oe, 0);
    chk(status == '0, "R1", "status in reset", status, 0);
    chk(qmode == 1'b0, "R1", "mode in reset", qmode, 0);
    rst_n = 1'b1;
    // R2 first start timed from reset, not checked
    run_cycle(17'h00001, 1'b0, 0, 1'b0);
    period = 8'd0; stop_idle = 3'd0;
    run_cycle(17'h1FFFF, 1'b0, 0, 1'b1);
    period = 8'd3; stop_idle = 3'd7; quiet_req = 1'b1;
    run_cycle(17'(($urandom)), 1'b1, 0, 1'b1);
    // quiet: long gap, slave starts
    run_cycle(17'h15555, 1'b1, 40, 1'b0);
    // quiet: slave starts in the very first idle state, then back to continuous
    quiet_req = 1'b0;
    run_cycle(17'h10004, 1'b1, 0, 1'b0);
    period = 8'd17;
    run_cycle(17'h00000, 1'b1, 0, 1'b1);
    for (int i = 0; i < 12; i++) begin
      period    = 8'($urandom % 40);
      stop_idle = 3'($urandom % 8);
      quiet_req = 1'($urandom % 2);
      run_cycle(17'($urandom), 1'b1, int'($urandom % 20), 1'b1);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule